// File: doc/BRIEF.md
# Baud-Rate Timing Error Phase Tracker

This block closes a first-order timing-recovery loop for a serial receiver that digitises its input with an ADC. It takes one signed multi-bit sample per symbol and slices it into a binary decision, where the sign gives +1 or -1. From the present and previous sample/decision pairs it forms a baud-rate timing error. It takes no edge sample. The error is summed in a signed accumulator. When the sum reaches a programmable threshold, a 16-position sampling-phase pointer steps one position toward the sign of the sum and the sum clears. The pointer drives an external clock-phase selector. The loop settles where the pre-cursor and post-cursor ISI balance, because there the mean error is zero.

Control runs through a two-state machine. In `ST_PRIME` no history sample exists yet. The first valid sample after reset is only stored, and the transition `PRIME_TO_TRACK` fires on that sample. In `ST_TRACK` every valid sample produces an error and updates the accumulator; the transition `TRACK_HOLD` keeps the machine there until reset. Cycles without a valid sample leave all state untouched. The detector relies on residual ISI. On a symmetric alternating pattern the error is identically zero, so the pointer does not move, wherever it sits.

Top module: `mm_phase_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block loads `phase_idx` from `start_phase`, clears `ted_error` and the accumulator, sets `decision` to 0 and enters `ST_PRIME`.
- R2: On a valid sample, `decision` becomes 1 (+1) when the sample's sign bit is 0 (value >= 0) and 0 (-1) when it is negative; it is registered and visible after that edge.
- R3: The first valid sample after reset produces `ted_error` = 0, leaves the accumulator and `phase_idx` unchanged, and is kept as history.
- R4: Each later valid sample k drives `ted_error` to v[k]*d[k-1] - v[k-1]*d[k], with d = +1/-1, as a full-precision signed value of SAMPLE_W+2 bits, after that edge.
- R5: The sum S = accumulator + error is formed. If S is nonzero and |S| >= `threshold`, then `phase_idx` steps +1 for S > 0 or -1 for S < 0, and the accumulator clears. Otherwise the accumulator takes S and `phase_idx` holds.
- R6: `phase_idx` wraps modulo 16: one step up from 15 gives 0, and one step down from 0 gives 15.
- R7: A cycle with `sample_valid` low changes none of `decision`, `ted_error`, `phase_idx` or the accumulator.
- R8: A symmetric alternating input (+a, -a, +a, ...) yields `ted_error` = 0 on every sample, so `phase_idx` never moves, even with a threshold of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Sample present this cycle |
| sample | input | SAMPLE_W | Signed ADC sample, one per symbol |
| threshold | input | THR_W | Accumulator magnitude that triggers a phase step |
| start_phase | input | PHASE_W | Phase loaded by reset |
| decision | output | 1 | Sliced symbol, 1 = +1, 0 = -1 |
| ted_error | output | SAMPLE_W+2 | Signed timing error of the last sample |
| phase_idx | output | PHASE_W | Sampling-phase pointer, 0..15 |

## Verification
Directed pairs of samples with known values fix the sign and size of the error formula and the priming of the first sample. Rising and falling positive ramps at threshold 1 drive the pointer across its 15/0 boundary in each direction. A symmetric alternating pattern checks that the error vanishes and the phase stays put. Long random sample streams with random gaps in valid and changing thresholds then separate correct accumulate/clear behaviour from off-by-one threshold compares and from updates on idle cycles.

// File: rtl/mm_track_pkg.sv
package mm_track_pkg;
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;
endpackage

// File: rtl/mm_slicer.sv
module mm_slicer #(
    parameter int SAMPLE_W = 8
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       dec_pos
);
    // Binary slice at zero: non-negative maps to +1
    assign dec_pos = ~sample[SAMPLE_W-1];
endmodule

// File: rtl/mm_ted.sv
module mm_ted #(
    parameter int SAMPLE_W = 8,
    localparam int ERR_W = SAMPLE_W + 2
) (
    input  logic signed [SAMPLE_W-1:0] cur_sample,
    input  logic                       cur_pos,
    input  logic signed [SAMPLE_W-1:0] prv_sample,
    input  logic                       prv_pos,
    output logic signed [ERR_W-1:0]    err
);
    logic signed [ERR_W-1:0] cur_ext, prv_ext, term_a, term_b;

    assign cur_ext = {{(ERR_W-SAMPLE_W){cur_sample[SAMPLE_W-1]}}, cur_sample};
    assign prv_ext = {{(ERR_W-SAMPLE_W){prv_sample[SAMPLE_W-1]}}, prv_sample};

    // Multiplying by +/-1 reduces to a conditional negation
    assign term_a = prv_pos ? cur_ext : -cur_ext;
    assign term_b = cur_pos ? prv_ext : -prv_ext;
    assign err    = term_a - term_b;
endmodule

// File: rtl/mm_loop_filter.sv
module mm_loop_filter #(
    parameter int ERR_W = 10,
    parameter int THR_W = 8,
    localparam int ACC_W = ((THR_W > ERR_W) ? THR_W : ERR_W) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic signed [ERR_W-1:0] err,
    input  logic [THR_W-1:0]        threshold,
    output logic                    step_en,
    output logic                    step_up,
    output logic signed [ACC_W-1:0] acc_q
);
    logic signed [ACC_W-1:0] err_ext, acc_sum;
    logic        [ACC_W-1:0] sum_mag, thr_ext;
    logic                    hit;

    assign err_ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
    assign thr_ext = {{(ACC_W-THR_W){1'b0}}, threshold};

    always_comb begin
        acc_sum = acc_q + err_ext;
        sum_mag = acc_sum[ACC_W-1] ? ACC_W'(-acc_sum) : ACC_W'(acc_sum);
        hit     = (acc_sum != '0) && (sum_mag >= thr_ext);
    end

    assign step_en = upd_en && hit;
    assign step_up = ~acc_sum[ACC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (upd_en) begin
            acc_q <= hit ? '0 : acc_sum;
        end
    end
endmodule

// File: rtl/mm_phase_ptr.sv
module mm_phase_ptr #(
    parameter int PHASES = 16,
    localparam int PHASE_W = $clog2(PHASES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] start_phase,
    input  logic               step_en,
    input  logic               step_up,
    output logic [PHASE_W-1:0] phase_q
);
    localparam logic [PHASE_W-1:0] TOP = PHASE_W'(PHASES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= start_phase;
        end else if (step_en) begin
            if (step_up) begin
                phase_q <= (phase_q == TOP) ? '0 : phase_q + 1'b1;
            end else begin
                phase_q <= (phase_q == '0) ? TOP : phase_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/mm_phase_tracker.sv
module mm_phase_tracker
    import mm_track_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int THR_W    = 8,
    parameter int PHASES   = 16,
    localparam int PHASE_W = $clog2(PHASES),
    localparam int ERR_W   = SAMPLE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [THR_W-1:0]           threshold,
    input  logic [PHASE_W-1:0]         start_phase,
    output logic                       decision,
    output logic signed [ERR_W-1:0]    ted_error,
    output logic [PHASE_W-1:0]         phase_idx
);
    localparam int ACC_W = ((THR_W > ERR_W) ? THR_W : ERR_W) + 2;

    trk_state_t state_q, state_d;

    logic                       dec_now;
    logic signed [ERR_W-1:0]    err_now;
    logic signed [SAMPLE_W-1:0] v_prev_q;
    logic                       d_prev_q;
    logic                       track_en;
    logic                       tracking;
    logic                       step_en, step_up;
    logic signed [ACC_W-1:0]    acc_q;

    // Next-state logic: PRIME_TO_TRACK on first valid sample, TRACK_HOLD after
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (sample_valid) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    assign tracking = (state_q == ST_TRACK);
    assign track_en = sample_valid && tracking;

    mm_slicer #(.SAMPLE_W(SAMPLE_W)) u_slicer (
        .sample  (sample),
        .dec_pos (dec_now)
    );

    mm_ted #(.SAMPLE_W(SAMPLE_W)) u_ted (
        .cur_sample (sample),
        .cur_pos    (dec_now),
        .prv_sample (v_prev_q),
        .prv_pos    (d_prev_q),
        .err        (err_now)
    );

    mm_loop_filter #(.ERR_W(ERR_W), .THR_W(THR_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (track_en),
        .err       (err_now),
        .threshold (threshold),
        .step_en   (step_en),
        .step_up   (step_up),
        .acc_q     (acc_q)
    );

    mm_phase_ptr #(.PHASES(PHASES)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_phase (start_phase),
        .step_en     (step_en),
        .step_up     (step_up),
        .phase_q     (phase_idx)
    );

    // Output and history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decision  <= 1'b0;
            ted_error <= '0;
            v_prev_q  <= '0;
            d_prev_q  <= 1'b0;
        end else if (sample_valid) begin
            decision <= dec_now;
            v_prev_q <= sample;
            d_prev_q <= dec_now;
            unique case (state_q)
                ST_PRIME: ted_error <= '0;
                ST_TRACK: ted_error <= err_now;
                default:  ted_error <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mm_phase_tracker_chk.sv
module mm_phase_tracker_chk #(
    parameter int SAMPLE_W = 8,
    parameter int THR_W    = 8,
    parameter int PHASES   = 16,
    parameter int PHASE_W  = 4,
    parameter int ERR_W    = 10,
    parameter int ACC_W    = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sample_valid,
    input logic signed [SAMPLE_W-1:0] sample,
    input logic [THR_W-1:0]           threshold,
    input logic [PHASE_W-1:0]         start_phase,
    input logic                       decision,
    input logic signed [ERR_W-1:0]    ted_error,
    input logic [PHASE_W-1:0]         phase_idx,
    input logic                       tracking,
    input logic signed [ACC_W-1:0]    acc
);
    localparam logic [PHASE_W-1:0] TOP = PHASE_W'(PHASES - 1);

    logic [PHASE_W-1:0] nb_up, nb_dn;
    logic [ACC_W-1:0]   acc_mag;

    assign nb_up   = (phase_idx == TOP) ? '0 : phase_idx + 1'b1;
    assign nb_dn   = (phase_idx == '0) ? TOP : phase_idx - 1'b1;
    assign acc_mag = acc[ACC_W-1] ? ACC_W'(-acc) : ACC_W'(acc);

    // R1
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_idx == $past(start_phase)) && (ted_error == '0) && !tracking);

    // R2
    slice_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> decision == !$past(sample[SAMPLE_W-1]));

    // R3
    prime_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !tracking) |=> (ted_error == '0) && tracking && $stable(phase_idx));

    // R5
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && tracking) |=> (acc == '0) || (acc_mag < {{(ACC_W-THR_W){1'b0}}, $past(threshold)}));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> (phase_idx == $past(phase_idx)) || (phase_idx == $past(nb_up))
                         || (phase_idx == $past(nb_dn)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(phase_idx) && $stable(ted_error) && $stable(decision) && $stable(acc));
endmodule

bind mm_phase_tracker mm_phase_tracker_chk #(
    .SAMPLE_W (SAMPLE_W),
    .THR_W    (THR_W),
    .PHASES   (PHASES),
    .PHASE_W  (PHASE_W),
    .ERR_W    (ERR_W),
    .ACC_W    (ACC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample       (sample),
    .threshold    (threshold),
    .start_phase  (start_phase),
    .decision     (decision),
    .ted_error    (ted_error),
    .phase_idx    (phase_idx),
    .tracking     (tracking),
    .acc          (acc_q)
);

// File: tb/sim_mm_phase_tracker.sv
`timescale 1ns/1ps
module sim_mm_phase_tracker;
    localparam int SW = 8;
    localparam int TW = 8;
    localparam int NP = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] sample = '0;
    logic [TW-1:0]        threshold = 8'd10;
    logic [3:0]           start_phase = 4'd0;
    logic                 decision;
    logic signed [SW+1:0] ted_error;
    logic [3:0]           phase_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected-state model
    bit m_primed;
    int m_vprev, m_dprev, m_acc, m_err, m_phase, m_dec;

    always #10 clk = ~clk;

    mm_phase_tracker #(.SAMPLE_W(SW), .THR_W(TW), .PHASES(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
        .threshold(threshold), .start_phase(start_phase), .decision(decision),
        .ted_error(ted_error), .phase_idx(phase_idx)
    );

    function automatic int sgn1(input int v);
        return (v >= 0) ? 1 : -1;
    endfunction

    function automatic int wrap_step(input int p, input bit up);
        if (up) return (p == NP - 1) ? 0 : p + 1;
        return (p == 0) ? NP - 1 : p - 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int sp);
        sample_valid = 1'b0;
        rst_n = 1'b0;
        start_phase = 4'(sp);
        repeat (2) @(negedge clk);
        m_primed = 0; m_acc = 0; m_err = 0; m_phase = sp; m_dec = 0;
        m_vprev = 0; m_dprev = -1;
        chk("R1 phase", int'(phase_idx), sp);
        chk("R1 error", int'(ted_error), 0);
        chk("R1 decision", int'(decision), 0);
        rst_n = 1'b1;
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic apply(input bit vld, input int s, input string ptag);
        bit first;
        int d, e, sum, mag;
        sample_valid = vld;
        sample = SW'(s);
        @(posedge clk);
        first = !m_primed;
        if (vld) begin
            d = sgn1(s);
            if (!m_primed) begin
                m_primed = 1;
                m_err = 0;
            end else begin
                e = s * m_dprev - m_vprev * d;
                m_err = e;
                sum = m_acc + e;
                mag = (sum < 0) ? -sum : sum;
                if (sum != 0 && mag >= int'(threshold)) begin
                    m_phase = wrap_step(m_phase, sum > 0);
                    m_acc = 0;
                end else begin
                    m_acc = sum;
                end
            end
            m_vprev = s; m_dprev = d; m_dec = (d > 0) ? 1 : 0;
        end
        @(negedge clk);
        if (!vld) begin
            chk("R7 decision", int'(decision), m_dec);
            chk("R7 error", int'(ted_error), m_err);
            chk("R7 phase", int'(phase_idx), m_phase);
        end else begin
            chk("R2 decision", int'(decision), m_dec);
            chk(first ? "R3 error" : "R4 error", int'(ted_error), m_err);
            chk(first ? "R3 phase" : ptag, int'(phase_idx), m_phase);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        do_reset(5);

        // directed error values
        threshold = 8'd100;
        apply(1, 20, "R5 phase");        // priming
        apply(1, -30, "R5 phase");       // -30*1 - 20*(-1) = -10
        chk("R4 known value", int'(ted_error), -10);
        apply(0, 77, "R7 phase");
        apply(1, -30, "R5 phase");       // 30 - 30 = 0
        chk("R4 zero value", int'(ted_error), 0);
        apply(1, 127, "R5 phase");       // 127*(-1) - (-30)*1 = -97
        chk("R4 extreme", int'(ted_error), -97);

        // upward wrap
        do_reset(15);
        threshold = 8'd1;
        apply(1, 10, "R6 phase");
        apply(1, 20, "R6 phase");
        chk("R6 wrap up", int'(phase_idx), 0);

        // downward wrap
        do_reset(0);
        apply(1, 20, "R6 phase");
        apply(1, 10, "R6 phase");
        chk("R6 wrap down", int'(phase_idx), 15);

        // threshold exactly reached after accumulation
        do_reset(8);
        threshold = 8'd20;
        apply(1, 10, "R5 phase");
        apply(1, 20, "R5 phase");        // +10, acc 10
        apply(1, 29, "R5 phase");        // +9, acc 19
        chk("R5 below thr", int'(phase_idx), 8);
        apply(1, 30, "R5 phase");        // +1, acc 20 -> step
        chk("R5 at thr", int'(phase_idx), 9);

        // symmetric clock pattern
        do_reset(7);
        threshold = 8'd1;
        for (int i = 0; i < 40; i++) begin
            apply(1, (i % 2 == 0) ? 40 : -40, "R8 phase");
            chk("R8 error", int'(ted_error), 0);
        end
        chk("R8 phase held", int'(phase_idx), 7);

        // random streams
        do_reset(3);
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) threshold = TW'($urandom_range(0, 60));
            apply(($urandom_range(0, 3) != 0), $signed(SW'($urandom)) , "R5 phase");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..all: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule